// File: doc/BRIEF.md
# Dual-Display Vertical Scan Mapper

This block generates the vertical timing shared by a CRT and an LCD panel that show the same picture at the same time. A single vertical counter, paced by the CRT, steps once per scan line over a frame of `TOTAL_LINES` lines. The first `ACTIVE_LINES` lines are visible and the rest are vertical retrace. For every new CRT line the block reports three things: whether the line is visible, which image line the CRT must fetch, and whether the LCD takes that line. When the LCD takes a line, the block also reports the LCD row it lands on and the image line it shows.

A 2-bit mapping policy selects how one 480-line CRT raster feeds the panel. The four policies are:

- Direct: CRT and LCD show the same lines.
- Line doubling: a half-height image is doubled on the CRT.
- Alternating-field interlace: a half-height panel shows even image lines on one frame and odd lines on the next.
- Even-only: the panel always shows even image lines.

Retrace always follows the CRT frame, so the LCD line rate is set by the CRT timing. The policy is read from an 8-bit display configuration byte. It is latched only at the start of a frame, so that one frame never mixes two policies.

Top module: `dsm_scan_mapper`

## Requirements
- R1: The vertical line counter advances on each `line_tick` pulse, from 0 up to `TOTAL_LINES-1`, and then wraps to 0. The first tick after reset starts line 0. `frame_start` is high for exactly the one cycle after the tick that starts line 0, so frame starts are `TOTAL_LINES` ticks apart.
- R2: All outputs for a line are registered and appear in the cycle after its tick. `crt_active` is 1 for lines 0 to `ACTIVE_LINES-1` and 0 during retrace. `lcd_valid` is high for at most the one cycle after a tick, and never while `crt_active` is 0.
- R3: With policy 00 (direct) on active line L: `crt_img_line`=L, `lcd_valid`=1, `lcd_img_line`=L and `lcd_line`=L.
- R4: With policy 01 (line doubling) on active line L: `crt_img_line`=L/2 (rounded down). `lcd_valid`=1 only when L is even, and then `lcd_img_line`=`lcd_line`=L/2.
- R5: With policy 10 (interlace) on active line L: `crt_img_line`=L. `lcd_valid`=1 only when bit 0 of L equals the frame's field bit, and then `lcd_img_line`=L and `lcd_line`=L/2. The field bit is 0 for the first frame after reset and inverts at every later frame start.
- R6: With policy 11 (even-only) on active line L: `crt_img_line`=L. `lcd_valid`=1 only when L is even, on every frame, and then `lcd_img_line`=L and `lcd_line`=L/2.
- R7: The policy is bits 6:5 of `disp_cfg`. It is sampled only on the tick that starts line 0 and holds for the whole frame. Bit 7 and bits 4:0 have no effect on any output.
- R8: `lcd_line` and `lcd_img_line` change only in cycles where `lcd_valid` is 1, and otherwise hold their value. `lcd_line` is 0 on the first LCD line of each frame. `crt_img_line` is 0 whenever `crt_active` is 0.
- R9: Synchronous active-high reset clears `crt_active`, `lcd_valid`, `frame_start`, `crt_img_line`, `lcd_line` and `lcd_img_line` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-cycle pulse at the start of each CRT scan line |
| disp_cfg | input | 8 | Display configuration byte; bits 6:5 select the mapping policy |
| crt_active | output | 1 | Current CRT line is visible |
| crt_img_line | output | 9 | Image line fetched for the CRT on the current line |
| lcd_valid | output | 1 | One-cycle strobe: the LCD takes the current line |
| lcd_line | output | 9 | LCD row of the most recent LCD line |
| lcd_img_line | output | 9 | Image line shown on that LCD row |
| frame_start | output | 1 | One-cycle pulse when line 0 begins |

## Verification
On every cycle the assertions check several port-level rules:

- `frame_start` and `lcd_valid` occur only right after a tick.
- Frame starts are exactly one full frame of ticks apart.
- The LCD strobe never fires during retrace.
- The LCD index and image outputs hold between strobes, and the first LCD line of a frame has index 0.
- `crt_img_line` stays in range and is zero in retrace.

Only the bench's frame-by-frame sweep can show the mapping policies themselves. That sweep covers the field alternation across two interlace frames, the even-only selection, and the line halving under doubling. It also shows that a policy written mid-frame waits for the next frame, and that the unused configuration bits change nothing.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    // Mapping policies, as encoded in disp_cfg[6:5]
    typedef enum logic [1:0] {
        MAP_DIRECT    = 2'b00,
        MAP_DOUBLE    = 2'b01,
        MAP_ALT_FIELD = 2'b10,
        MAP_EVEN_ONLY = 2'b11
    } map_mode_e;

    localparam int MODE_LSB = 5;

    // Per-line decision taken from the policy
    typedef struct packed {
        logic lcd_take;   // panel takes this line
        logic img_halve;  // image line is the scan line divided by two
    } line_plan_t;

    function automatic map_mode_e cfg_to_mode(input logic [7:0] cfg);
        return map_mode_e'(cfg[MODE_LSB+1:MODE_LSB]);
    endfunction

    function automatic line_plan_t plan_line(input map_mode_e mode,
                                             input logic      odd_line,
                                             input logic      field);
        line_plan_t p;
        p.img_halve = 1'b0;
        p.lcd_take  = 1'b1;
        case (mode)
            MAP_DIRECT:    p.lcd_take = 1'b1;
            MAP_DOUBLE: begin
                p.img_halve = 1'b1;
                p.lcd_take  = ~odd_line;
            end
            MAP_ALT_FIELD: p.lcd_take = (odd_line == field);
            MAP_EVEN_ONLY: p.lcd_take = ~odd_line;
            default:       p.lcd_take = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dsm_vcount.sv
module dsm_vcount #(
    parameter int TOTAL_LINES  = 525,
    parameter int ACTIVE_LINES = 480,
    parameter int CNT_W        = $clog2(TOTAL_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_tick,
    output logic [CNT_W-1:0] nxt_line,
    output logic             nxt_wrap,
    output logic             nxt_active
);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(TOTAL_LINES - 1);
    localparam logic [CNT_W-1:0] VISIBLE = CNT_W'(ACTIVE_LINES);

    logic [CNT_W-1:0] line_q;

    // Line that the next tick begins
    always_comb begin
        nxt_line   = (line_q == LAST) ? '0 : line_q + 1'b1;
        nxt_wrap   = (line_q == LAST);
        nxt_active = (nxt_line < VISIBLE);
    end

    // Reset parks on the last line so the first tick opens line 0
    always_ff @(posedge clk) begin
        if (rst)
            line_q <= LAST;
        else if (line_tick)
            line_q <= nxt_line;
    end
endmodule

// File: rtl/dsm_cfg_shadow.sv
module dsm_cfg_shadow
    import dsm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line_tick,
    input  logic      nxt_wrap,
    input  logic [7:0] disp_cfg,
    output map_mode_e mode_eff,
    output logic      field_eff
);
    map_mode_e mode_q;
    logic      field_q;
    logic      primed_q;

    // At a frame boundary the new frame's values are used straight away
    always_comb begin
        if (nxt_wrap) begin
            mode_eff  = cfg_to_mode(disp_cfg);
            field_eff = primed_q ? ~field_q : 1'b0;
        end else begin
            mode_eff  = mode_q;
            field_eff = field_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MAP_DIRECT;
            field_q  <= 1'b0;
            primed_q <= 1'b0;
        end else if (line_tick && nxt_wrap) begin
            mode_q   <= mode_eff;
            field_q  <= field_eff;
            primed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/dsm_lcd_index.sv
module dsm_lcd_index #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_tick,
    input  logic             nxt_wrap,
    input  logic             take,
    output logic [IDX_W-1:0] idx_eff
);
    logic [IDX_W-1:0] used_q;

    // Row that a taken line would land on
    always_comb idx_eff = nxt_wrap ? '0 : used_q;

    always_ff @(posedge clk) begin
        if (rst)
            used_q <= '0;
        else if (line_tick)
            used_q <= idx_eff + IDX_W'(take);
    end
endmodule

// File: rtl/dsm_scan_mapper.sv
module dsm_scan_mapper
    import dsm_pkg::*;
#(
    parameter int TOTAL_LINES  = 525,
    parameter int ACTIVE_LINES = 480,
    parameter int CNT_W        = $clog2(TOTAL_LINES),
    parameter int IMG_W        = $clog2(ACTIVE_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_tick,
    input  logic [7:0]       disp_cfg,
    output logic             crt_active,
    output logic [IMG_W-1:0] crt_img_line,
    output logic             lcd_valid,
    output logic [IMG_W-1:0] lcd_line,
    output logic [IMG_W-1:0] lcd_img_line,
    output logic             frame_start
);
    logic [CNT_W-1:0] nxt_line;
    logic             nxt_wrap;
    logic             nxt_active;
    map_mode_e        mode_eff;
    logic             field_eff;
    line_plan_t       plan;
    logic             take;
    logic [IMG_W-1:0] idx_eff;
    logic [IMG_W-1:0] img_full;
    logic [IMG_W-1:0] img_sel;

    dsm_vcount #(
        .TOTAL_LINES (TOTAL_LINES),
        .ACTIVE_LINES(ACTIVE_LINES),
        .CNT_W       (CNT_W)
    ) u_vcount (
        .clk       (clk),
        .rst       (rst),
        .line_tick (line_tick),
        .nxt_line  (nxt_line),
        .nxt_wrap  (nxt_wrap),
        .nxt_active(nxt_active)
    );

    dsm_cfg_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .line_tick(line_tick),
        .nxt_wrap (nxt_wrap),
        .disp_cfg (disp_cfg),
        .mode_eff (mode_eff),
        .field_eff(field_eff)
    );

    always_comb begin
        plan     = plan_line(mode_eff, nxt_line[0], field_eff);
        take     = nxt_active & plan.lcd_take;
        img_full = IMG_W'(nxt_line);
        img_sel  = plan.img_halve ? (img_full >> 1) : img_full;
    end

    dsm_lcd_index #(
        .IDX_W(IMG_W)
    ) u_index (
        .clk      (clk),
        .rst      (rst),
        .line_tick(line_tick),
        .nxt_wrap (nxt_wrap),
        .take     (take),
        .idx_eff  (idx_eff)
    );

    // Output stage: one register between tick and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            crt_active   <= 1'b0;
            crt_img_line <= '0;
            lcd_valid    <= 1'b0;
            lcd_line     <= '0;
            lcd_img_line <= '0;
            frame_start  <= 1'b0;
        end else if (line_tick) begin
            crt_active   <= nxt_active;
            crt_img_line <= nxt_active ? img_sel : '0;
            lcd_valid    <= take;
            frame_start  <= nxt_wrap;
            if (take) begin
                lcd_line     <= idx_eff;
                lcd_img_line <= img_sel;
            end
        end else begin
            lcd_valid   <= 1'b0;
            frame_start <= 1'b0;
        end
    end
endmodule

// File: rtl/dsm_checker.sv
module dsm_checker #(
    parameter int TOTAL_LINES  = 525,
    parameter int ACTIVE_LINES = 480,
    parameter int IMG_W        = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             line_tick,
    input logic             crt_active,
    input logic [IMG_W-1:0] crt_img_line,
    input logic             lcd_valid,
    input logic [IMG_W-1:0] lcd_line,
    input logic [IMG_W-1:0] lcd_img_line,
    input logic             frame_start
);
    localparam int TW = $clog2(TOTAL_LINES + 2);

    logic [TW-1:0] ticks_q;
    logic          seen_q;

    // Ticks since the previous frame start
    always_ff @(posedge clk) begin
        if (rst) begin
            ticks_q <= '0;
            seen_q  <= 1'b0;
        end else if (frame_start) begin
            ticks_q <= TW'(line_tick);
            seen_q  <= 1'b1;
        end else if (line_tick) begin
            ticks_q <= ticks_q + 1'b1;
        end
    end

    p_frame_after_tick_r1: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> $past(line_tick));

    p_frame_len_r1: assert property (@(posedge clk) disable iff (rst)
        (frame_start && seen_q) |-> (ticks_q == TW'(TOTAL_LINES)));

    p_strobe_after_tick_r2: assert property (@(posedge clk) disable iff (rst)
        lcd_valid |-> $past(line_tick));

    p_no_lcd_in_retrace_r2: assert property (@(posedge clk) disable iff (rst)
        lcd_valid |-> crt_active);

    p_img_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        crt_img_line < IMG_W'(ACTIVE_LINES));

    p_retrace_img_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !crt_active |-> (crt_img_line == '0));

    p_lcd_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !lcd_valid |-> ($stable(lcd_line) && $stable(lcd_img_line)));

    p_first_row_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (lcd_valid && frame_start) |-> (lcd_line == '0));

    p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!lcd_valid && !frame_start && !crt_active));
endmodule

bind dsm_scan_mapper dsm_checker #(
    .TOTAL_LINES (TOTAL_LINES),
    .ACTIVE_LINES(ACTIVE_LINES),
    .IMG_W       (IMG_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_tick   (line_tick),
    .crt_active  (crt_active),
    .crt_img_line(crt_img_line),
    .lcd_valid   (lcd_valid),
    .lcd_line    (lcd_line),
    .lcd_img_line(lcd_img_line),
    .frame_start (frame_start)
);

// File: tb/sim_dsm_scan_mapper.sv
module sim_dsm_scan_mapper;
    localparam int TOTAL  = 525;
    localparam int ACTIVE = 480;
    localparam int NFR    = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_tick = 1'b0;
    logic [7:0] disp_cfg = 8'h00;
    logic       crt_active, lcd_valid, frame_start;
    logic [8:0] crt_img_line, lcd_line, lcd_img_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    dsm_scan_mapper u0 (
        .clk(clk), .rst(rst), .line_tick(line_tick), .disp_cfg(disp_cfg),
        .crt_active(crt_active), .crt_img_line(crt_img_line),
        .lcd_valid(lcd_valid), .lcd_line(lcd_line),
        .lcd_img_line(lcd_img_line), .frame_start(frame_start)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Policy per frame; the last entry only feeds the final frame boundary
    int plan [NFR+1] = '{0, 1, 2, 2, 3, 0, 0};

    initial begin
        int hold_line = 0;
        int hold_img  = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 crt_active", crt_active, 0);
        chk("R9 lcd_valid", lcd_valid, 0);
        chk("R9 frame_start", frame_start, 0);
        chk("R9 crt_img_line", crt_img_line, 0);
        chk("R9 lcd_line", lcd_line, 0);
        chk("R9 lcd_img_line", lcd_img_line, 0);

        for (int f = 0; f < NFR; f++) begin
            for (int ln = 0; ln < TOTAL; ln++) begin
                int  m, cfgm, e_crt, e_line, e_img;
                bit  act, take, fld;
                string tg;
                m    = plan[f];
                fld  = f[0];
                // Mode bits change mid-frame at line 200; junk in other bits (R7)
                cfgm = (ln >= 200) ? plan[f+1] : plan[f];
                disp_cfg  = {ln[0], cfgm[1:0], ln[4:0] ^ 5'h15};
                line_tick = 1'b1;
                @(negedge clk);
                line_tick = 1'b0;

                act   = (ln < ACTIVE);
                e_crt = act ? ((m == 1) ? ln / 2 : ln) : 0;
                case (m)
                    0: take = act;
                    2: take = act && (ln % 2 == int'(fld));
                    default: take = act && (ln % 2 == 0);
                endcase
                e_line = (m == 0) ? ln : ln / 2;
                e_img  = (m == 1) ? ln / 2 : ln;
                case (m)
                    0: tg = "R3";
                    1: tg = "R4";
                    2: tg = "R5";
                    default: tg = "R6";
                endcase
                if (take) begin
                    hold_line = e_line;
                    hold_img  = e_img;
                end
                chk("R1 frame_start", frame_start, int'(ln == 0));
                chk("R2 crt_active", crt_active, int'(act));
                chk({tg, " R7 crt_img_line"}, crt_img_line, e_crt);
                chk({tg, " R7 lcd_valid"}, lcd_valid, int'(take));
                chk({tg, " R8 lcd_line"}, lcd_line, hold_line);
                chk({tg, " R8 lcd_img_line"}, lcd_img_line, hold_img);

                // Gap cycle: strobes drop, LCD outputs hold
                @(negedge clk);
                chk("R1 frame_start pulse", frame_start, 0);
                chk("R2 lcd_valid pulse", lcd_valid, 0);
                chk("R8 lcd_line hold", lcd_line, hold_line);
                chk("R8 lcd_img_line hold", lcd_img_line, hold_img);
                chk("R2 crt_img_line hold", crt_img_line, e_crt);
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule